// File: doc/BRIEF.md
# Directory Coherence Controller

This block sits beside shared memory and keeps one directory entry for each block. An entry holds a presence bit for each private cache and an exclusive-owner flag. Caches send two kinds of request on a single request channel. A read request records the requester as a holder of the block. An upgrade request asks for write permission on a block the requester already holds.

For an upgrade, the controller pulses an invalidate to every other holder. The requester is then held stalled until each of those caches has acknowledged. Only after the last acknowledgment does the controller mark the entry exclusive, leave the requester as the only holder and return a write grant. If no other cache holds the block, the grant comes in the next cycle and no invalidate is sent.

The controller serves one transaction at a time. A new request is backpressured until the current one has been granted.

Top module: `dir_coh_ctrl`

## Requirements
- R1: After reset, every directory entry is clear (no holders, not exclusive), `req_ready_o` is high for any request on a clean block, and `grant_valid_o` and `inv_o` are low.
- R2: A read request (`req_type_i` = 0) on a block whose exclusive flag is clear is accepted. In the cycle after acceptance, a one-cycle grant appears with `grant_write_o` = 0 and the requester's cache and block, and the requester is added to the holders.
- R3: A read request on a block whose exclusive flag is set sees `req_ready_o` low and receives no grant.
- R4: An upgrade request (`req_type_i` = 1) from the controller's idle state is accepted. When no cache other than the requester holds the block, a grant with `grant_write_o` = 1 appears in the cycle after acceptance, and `inv_o` stays zero.
- R5: When other caches hold the block, the cycle after acceptance shows `inv_o` with exactly the other holders' bits set (bit i means cache i) and `inv_block_o` equal to the block. The pulse lasts one cycle and never includes the requester.
- R6: The write grant is withheld while any invalidated cache has not yet acknowledged. It appears in the cycle after the last outstanding acknowledgment.
- R7: After a write grant, the entry is exclusive and the requester is its only holder. As a result, reads from other caches stall, a repeated upgrade by the owner is granted with no invalidate, and an upgrade by another cache invalidates only the owner.
- R8: While an upgrade is waiting for acknowledgments, `req_ready_o` is low for every request. It returns high in the grant cycle.
- R9: An acknowledgment from a cache that was not invalidated, or a second acknowledgment from a cache that already answered, has no effect: the grant is still withheld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted at this edge when valid |
| req_cache_i | input | CACHE_W | Requesting cache index |
| req_block_i | input | BLK_W | Block index |
| req_type_i | input | 1 | 0 = read, 1 = upgrade |
| inv_o | output | NUM_CACHES | One-cycle invalidate, bit per cache |
| inv_block_o | output | BLK_W | Block being invalidated |
| ack_i | input | NUM_CACHES | Invalidate acknowledgment pulses, bit per cache |
| grant_valid_o | output | 1 | One-cycle grant |
| grant_cache_o | output | CACHE_W | Cache receiving the grant |
| grant_block_o | output | BLK_W | Granted block |
| grant_write_o | output | 1 | 1 = write permission, 0 = read recorded |

## Verification
The bench sweeps every block and, for each one, every subset of four caches as prior readers, with an upgrade from each of the four caches. This covers three situations. An empty set of other holders tells the fast grant apart from the invalidate path. A set holding only the requester shows that the requester is excluded from the invalidate. A full set shows that the grant waits for every acknowledgment.

Each upgrade is salted with an acknowledgment from the requester and with repeated acknowledgments, to show that strays are ignored. A competing request is held during the wait, to show that requests are serialized. Follow-up reads from another cache, a repeated upgrade by the owner, and an ownership transfer show that the directory ended exclusive with a single holder.

// File: rtl/dir_coh_pkg.sv
package dir_coh_pkg;
  typedef enum logic {
    REQ_READ    = 1'b0,
    REQ_UPGRADE = 1'b1
  } req_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/dir_coh_store.sv
module dir_coh_store #(
  parameter int NUM_CACHES = 4,
  parameter int NUM_BLOCKS = 16,
  parameter int BLK_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [BLK_W-1:0]      rd_blk_i,
  output logic [NUM_CACHES-1:0] rd_sharers_o,
  output logic                  rd_dirty_o,
  input  logic                  wr_en_i,
  input  logic [BLK_W-1:0]      wr_blk_i,
  input  logic [NUM_CACHES-1:0] wr_sharers_i,
  input  logic                  wr_dirty_i
);

  logic [NUM_CACHES-1:0] sharers_q [NUM_BLOCKS];
  logic                  dirty_q   [NUM_BLOCKS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_BLOCKS; i++) begin
        sharers_q[i] <= '0;
        dirty_q[i]   <= 1'b0;
      end
    end else if (wr_en_i) begin
      sharers_q[wr_blk_i] <= wr_sharers_i;
      dirty_q[wr_blk_i]   <= wr_dirty_i;
    end
  end

  assign rd_sharers_o = sharers_q[rd_blk_i];
  assign rd_dirty_o   = dirty_q[rd_blk_i];

  // an exclusive entry names exactly one holder
  p_owner_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_dirty_i) |-> ($countones(wr_sharers_i) == 1));

endmodule

// File: rtl/dir_coh_ack_track.sv
module dir_coh_ack_track #(
  parameter int NUM_CACHES = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [NUM_CACHES-1:0] load_set_i,
  input  logic [NUM_CACHES-1:0] ack_i,
  output logic [NUM_CACHES-1:0] pending_o,
  output logic                  clear_o
);

  logic [NUM_CACHES-1:0] pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pending_q <= '0;
    else if (load_i)  pending_q <= load_set_i;
    else              pending_q <= pending_q & ~ack_i;
  end

  assign pending_o = pending_q;
  // last outstanding acknowledgment arrives this cycle
  assign clear_o   = (pending_q & ~ack_i) == '0;

  // stray or repeated acks never add outstanding bits
  p_no_new_pending_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ((pending_q & ~$past(pending_q)) == '0));

endmodule

// File: rtl/dir_coh_ctrl.sv
module dir_coh_ctrl
  import dir_coh_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int NUM_BLOCKS = 16,
  parameter int CACHE_W    = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1,
  parameter int BLK_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [CACHE_W-1:0]    req_cache_i,
  input  logic [BLK_W-1:0]      req_block_i,
  input  logic                  req_type_i,
  output logic [NUM_CACHES-1:0] inv_o,
  output logic [BLK_W-1:0]      inv_block_o,
  input  logic [NUM_CACHES-1:0] ack_i,
  output logic                  grant_valid_o,
  output logic [CACHE_W-1:0]    grant_cache_o,
  output logic [BLK_W-1:0]      grant_block_o,
  output logic                  grant_write_o
);

  ctl_state_e            state_q;
  req_kind_e             kind;
  logic [NUM_CACHES-1:0] req_oh, cur_oh_q, rd_sharers, others, wr_sharers, pending;
  logic [BLK_W-1:0]      dir_blk, cur_blk_q;
  logic [CACHE_W-1:0]    cur_cache_q;
  logic                  rd_dirty, wr_en, wr_dirty, accept, track_load, track_clear;

  for (genvar gi = 0; gi < NUM_CACHES; gi++) begin : g_req_oh
    assign req_oh[gi] = (req_cache_i == CACHE_W'(gi));
  end

  assign kind        = req_kind_e'(req_type_i);
  assign dir_blk     = (state_q == ST_IDLE) ? req_block_i : cur_blk_q;
  assign others      = rd_sharers & ~req_oh;
  assign req_ready_o = (state_q == ST_IDLE) && !((kind == REQ_READ) && rd_dirty);
  assign accept      = req_valid_i && req_ready_o;

  dir_coh_store #(
    .NUM_CACHES (NUM_CACHES),
    .NUM_BLOCKS (NUM_BLOCKS),
    .BLK_W      (BLK_W)
  ) store_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_blk_i     (dir_blk),
    .rd_sharers_o (rd_sharers),
    .rd_dirty_o   (rd_dirty),
    .wr_en_i      (wr_en),
    .wr_blk_i     (dir_blk),
    .wr_sharers_i (wr_sharers),
    .wr_dirty_i   (wr_dirty)
  );

  dir_coh_ack_track #(
    .NUM_CACHES (NUM_CACHES)
  ) track_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (track_load),
    .load_set_i (others),
    .ack_i      (ack_i),
    .pending_o  (pending),
    .clear_o    (track_clear)
  );

  always_comb begin
    wr_en      = 1'b0;
    wr_sharers = rd_sharers;
    wr_dirty   = rd_dirty;
    track_load = 1'b0;
    if (state_q == ST_IDLE) begin
      if (accept) begin
        if (kind == REQ_READ) begin
          wr_en      = 1'b1;
          wr_sharers = rd_sharers | req_oh;
          wr_dirty   = 1'b0;
        end else if (others == '0) begin
          wr_en      = 1'b1;
          wr_sharers = req_oh;
          wr_dirty   = 1'b1;
        end else begin
          track_load = 1'b1;
        end
      end
    end else if (track_clear) begin
      // all invalidations answered: requester becomes sole owner
      wr_en      = 1'b1;
      wr_sharers = cur_oh_q;
      wr_dirty   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      cur_cache_q   <= '0;
      cur_blk_q     <= '0;
      cur_oh_q      <= '0;
      inv_o         <= '0;
      inv_block_o   <= '0;
      grant_valid_o <= 1'b0;
      grant_cache_o <= '0;
      grant_block_o <= '0;
      grant_write_o <= 1'b0;
    end else begin
      grant_valid_o <= 1'b0;
      inv_o         <= '0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            cur_cache_q <= req_cache_i;
            cur_blk_q   <= req_block_i;
            cur_oh_q    <= req_oh;
            if (kind == REQ_READ || others == '0) begin
              grant_valid_o <= 1'b1;
              grant_cache_o <= req_cache_i;
              grant_block_o <= req_block_i;
              grant_write_o <= (kind == REQ_UPGRADE);
            end else begin
              inv_o       <= others;
              inv_block_o <= req_block_i;
              state_q     <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (track_clear) begin
            grant_valid_o <= 1'b1;
            grant_cache_o <= cur_cache_q;
            grant_block_o <= cur_blk_q;
            grant_write_o <= 1'b1;
            state_q       <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_inv_skip_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> ((inv_o & cur_oh_q) == '0));

  p_inv_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_o != '0) |=> (inv_o == '0));

  p_hold_grant_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WAIT) && (pending & ~ack_i) != '0) |=> !grant_valid_o);

  p_wait_has_pending_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_WAIT) |-> (pending != '0));

endmodule

// File: tb/dir_coh_ctrl_tb_top.sv
`timescale 1ns/1ps
module dir_coh_ctrl_tb_top;
  localparam int NC = 4;
  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_cache = '0;
  logic [1:0]    req_block = '0;
  logic          req_type = 1'b0;
  logic [NC-1:0] inv;
  logic [1:0]    inv_block;
  logic [NC-1:0] ack = '0;
  logic          grant_valid;
  logic [1:0]    grant_cache;
  logic [1:0]    grant_block;
  logic          grant_write;

  int checks = 0;
  int errors = 0;
  logic [NC-1:0] sh_m [NB];
  logic          dirty_m [NB];

  always #2.5 clk = ~clk;

  dir_coh_ctrl #(.NUM_CACHES(NC), .NUM_BLOCKS(NB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_cache_i(req_cache), .req_block_i(req_block), .req_type_i(req_type),
    .inv_o(inv), .inv_block_o(inv_block), .ack_i(ack),
    .grant_valid_o(grant_valid), .grant_cache_o(grant_cache),
    .grant_block_o(grant_block), .grant_write_o(grant_write)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    req_valid = 1'b0;
    ack = '0;
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    for (int i = 0; i < NB; i++) begin
      sh_m[i] = '0;
      dirty_m[i] = 1'b0;
    end
    step();
  endtask

  task automatic do_read(input int c, input int b);
    req_valid = 1'b1; req_cache = 2'(c); req_block = 2'(b); req_type = 1'b0;
    #0.1;
    if (dirty_m[b]) begin
      check("R3 read on exclusive block ready", int'(req_ready), 0);
      step();
      req_valid = 1'b0;
      check("R3 no grant on stalled read", int'(grant_valid), 0);
      return;
    end
    check("R2 read ready", int'(req_ready), 1);
    step();
    req_valid = 1'b0;
    check("R2 read grant valid", int'(grant_valid), 1);
    check("R2 read grant write", int'(grant_write), 0);
    check("R2 read grant cache", int'(grant_cache), c);
    check("R2 read grant block", int'(grant_block), b);
    check("R2 read no invalidate", int'(inv), 0);
    sh_m[b][c] = 1'b1;
  endtask

  task automatic do_upg(input int c, input int b);
    logic [NC-1:0] oth, rem;
    int ob;
    oth = sh_m[b] & ~(NC'(1) << c);
    ob = (b + 1) % NB;
    req_valid = 1'b1; req_cache = 2'(c); req_block = 2'(b); req_type = 1'b1;
    #0.1;
    check("R4 upgrade ready", int'(req_ready), 1);
    step();
    if (oth == '0) begin
      req_valid = 1'b0;
      check("R4 fast grant valid", int'(grant_valid), 1);
      check("R4 fast grant write", int'(grant_write), 1);
      check("R4 fast grant cache", int'(grant_cache), c);
      check("R4 fast grant block", int'(grant_block), b);
      check("R4 no invalidate", int'(inv), 0);
    end else begin
      // competing read held during the wait
      req_type = 1'b0; req_block = 2'(ob);
      check("R5 invalidate set", int'(inv), int'(oth));
      check("R5 invalidate block", int'(inv_block), b);
      check("R6 no grant before acks", int'(grant_valid), 0);
      step();
      check("R5 invalidate one cycle", int'(inv), 0);
      check("R8 busy not ready", int'(req_ready), 0);
      ack = NC'(1) << c;
      step();
      ack = '0;
      check("R9 requester ack ignored", int'(grant_valid), 0);
      rem = oth;
      for (int k = 0; k < NC; k++) begin
        if (oth[k]) begin
          ack = NC'(1) << k;
          step();
          ack = '0;
          rem[k] = 1'b0;
          if (rem != '0) begin
            check("R6 grant held", int'(grant_valid), 0);
            check("R8 still busy", int'(req_ready), 0);
            ack = NC'(1) << k;
            step();
            ack = '0;
            check("R9 duplicate ack ignored", int'(grant_valid), 0);
          end else begin
            check("R6 grant after last ack", int'(grant_valid), 1);
            check("R6 grant write", int'(grant_write), 1);
            check("R6 grant cache", int'(grant_cache), c);
            check("R6 grant block", int'(grant_block), b);
            check("R8 ready in grant cycle", int'(req_ready), int'(!dirty_m[ob]));
          end
        end
      end
      req_valid = 1'b0;
    end
    sh_m[b] = NC'(1) << c;
    dirty_m[b] = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 ready after reset", int'(req_ready), 1);
    check("R1 no grant after reset", int'(grant_valid), 0);
    check("R1 no invalidate after reset", int'(inv), 0);
    for (int b = 0; b < NB; b++) begin
      for (int m = 0; m < (1 << NC); m++) begin
        for (int c = 0; c < NC; c++) begin
          do_reset();
          for (int k = 0; k < NC; k++) if (m[k]) do_read(k, b);
          do_upg(c, b);
          // R7: exclusive with single owner
          do_read((c + 1) % NC, b);
          do_upg(c, b);
          do_upg((c + 1) % NC, b);
        end
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule